// File: doc/BRIEF.md
# Hysteresis Edge Trigger Detector

This block decides when an acquisition should start. It watches a stream of signed 12-bit samples and compares each accepted sample with a programmable trigger level. It emits a one-cycle trigger pulse when the signal crosses that level in the selected direction. Before a channel crossing can fire, the detector must first be armed. Arming requires the signal to travel past the level on the opposite side by a hysteresis band of 5% of full scale, which is 205 codes. Noise sitting near the level therefore cannot produce a burst of triggers.

The trigger can also come from two other sources instead of the channel: an external-trigger strobe or a software-trigger strobe. A two-bit select picks the source. Each pulse carries the index of the sample it belongs to. The index comes from a free-running count of accepted samples.

The sample input has no back-pressure. The block takes a sample in every cycle that `smp_valid` is high, so it has no ready signal. The upstream source may hold `smp_valid` low for any number of cycles. Those cycles leave the block's state unchanged, except that a strobe arriving in one of them is recorded.

Top module: `hyst_edge_trigger`

## Requirements
- R1: After reset, `trig_pulse` is 0, `trig_index` is 0 and the detector is not armed.
- R2: Positive slope (`slope_neg`=0), channel source (`src_sel`=0):
  - An accepted sample at or below level−205 arms the detector.
  - The first later accepted sample at or above the level raises `trig_pulse` for exactly the one cycle after that sample is accepted.
- R3: Negative slope (`slope_neg`=1), channel source:
  - An accepted sample at or above level+205 arms the detector.
  - The first later accepted sample at or below the level fires the trigger, with the same timing as R2.
- R4: A sample inside the hysteresis band does not arm the detector. For positive slope with level 0, the sample −204 does not arm.
- R5: A channel trigger disarms the detector. No further channel trigger occurs until the detector is armed again.
- R6: `trig_level` is a 14-bit signed value. It is clamped into the sample range −2048..2047 before any comparison.
- R7: Software trigger (`src_sel`=2):
  - A `sw_trig` strobe produces exactly one pulse, on the first accepted sample at or after the strobe.
  - If a sample is accepted in the strobe's own cycle, that sample is used.
  - Sample values have no effect.
- R8: External trigger (`src_sel`=1):
  - An `ext_trig` strobe behaves like R7.
  - A strobe whose source is not selected at arrival is ignored. The same applies to every strobe while `src_sel`=3, which selects no source.
- R9: While `enable` is 0:
  - No pulse is produced.
  - The arm state and any pending strobe are cleared.
  - Strobes are dropped.
- R10: `trig_index` equals the number of samples accepted since reset before the triggering sample. The value is updated with each pulse and held until the next pulse.
- R11: A cycle with `smp_valid`=0 changes neither the arm state nor the sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Gates all trigger output; clears arm and pending state when low |
| smp_valid | input | 1 | Sample strobe; the sample is accepted in every cycle this is high |
| smp_data | input | 12 | Signed sample |
| trig_level | input | 14 | Signed trigger level, clamped to the sample range |
| slope_neg | input | 1 | 0 = fire on a rising crossing, 1 = fire on a falling crossing |
| src_sel | input | 2 | 0 = channel, 1 = external, 2 = software, 3 = none |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | External trigger strobe |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_index | output | 32 | Index of the triggering sample |

## Verification
Two of the block's functions can coincide in one cycle: a strobe arriving and a sample being accepted. In the coincident case, the bench drives the software strobe in the same cycle as a valid sample and expects the pulse right after that sample. In the split case, it drives the strobe with `smp_valid` low and expects nothing until the next valid sample, which must fire once and only once. Both cases are judged by the pulse timing and by the reported index. The bench also runs disable against a pending arm and a pending strobe to show that neither survives.

// File: rtl/trg_pkg.sv
package trg_pkg;
  typedef enum logic [1:0] {
    SRC_CHAN = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_SOFT = 2'd2,
    SRC_NONE = 2'd3
  } trg_src_e;
endpackage

// File: rtl/trg_level_clamp.sv
module trg_level_clamp #(
  parameter int SAMPLE_W = 12,
  parameter int LEVEL_W  = 14
) (
  input  logic signed [LEVEL_W-1:0]  lvl_raw,
  output logic signed [SAMPLE_W-1:0] lvl
);
  localparam int HI_I = 2**(SAMPLE_W-1) - 1;
  localparam int LO_I = -(2**(SAMPLE_W-1));

  int raw_i;

  always_comb begin
    raw_i = int'(lvl_raw);
    if (raw_i > HI_I)      lvl = SAMPLE_W'(HI_I);
    else if (raw_i < LO_I) lvl = SAMPLE_W'(LO_I);
    else                   lvl = SAMPLE_W'(raw_i);
  end
endmodule

// File: rtl/trg_hyst_arm.sv
module trg_hyst_arm #(
  parameter int SAMPLE_W = 12,
  parameter int HYST     = 205
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       valid,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic signed [SAMPLE_W-1:0] lvl,
  input  logic                       slope_neg,
  output logic                       fire,
  output logic                       armed
);
  int  s_i, l_i;
  logic crossed, arm_hit;

  always_comb begin
    s_i     = int'(smp);
    l_i     = int'(lvl);
    crossed = slope_neg ? (s_i <= l_i) : (s_i >= l_i);
    arm_hit = slope_neg ? (s_i >= l_i + HYST) : (s_i <= l_i - HYST);
    fire    = enable && valid && armed && crossed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               armed <= 1'b0;
    else if (!enable)         armed <= 1'b0;
    else if (valid) begin
      if (armed && crossed)   armed <= 1'b0;
      else if (arm_hit)       armed <= 1'b1;
    end
  end

  // R9
  dis_clears_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !armed);

  // R5
  fire_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);

  // R11
  idle_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !valid) |=> $stable(armed));
endmodule

// File: rtl/trg_src_select.sv
module trg_src_select
  import trg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       valid,
  input  logic [1:0] src_sel,
  input  logic       sw_stb,
  input  logic       ext_stb,
  input  logic       ch_fire,
  output logic       fire
);
  trg_src_e src;
  logic     stb_now, pend, strobe_path;

  always_comb begin
    src         = trg_src_e'(src_sel);
    stb_now     = ((src == SRC_EXT) && ext_stb) || ((src == SRC_SOFT) && sw_stb);
    strobe_path = (src == SRC_EXT) || (src == SRC_SOFT);
    fire = 1'b0;
    if (enable && valid) begin
      case (src)
        SRC_CHAN: fire = ch_fire;
        SRC_EXT,
        SRC_SOFT: fire = pend || stb_now;
        default:  fire = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                        pend <= 1'b0;
    else if (!enable)                                  pend <= 1'b0;
    else if (valid && strobe_path && (pend || stb_now)) pend <= 1'b0;
    else if (stb_now)                                  pend <= 1'b1;
  end

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pend);

  // R7
  pend_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && strobe_path) |=> !pend);
endmodule

// File: rtl/hyst_edge_trigger.sv
module hyst_edge_trigger
  import trg_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LEVEL_W  = 14,
  parameter int HYST_PCT = 5,
  parameter int CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [LEVEL_W-1:0]  trig_level,
  input  logic                slope_neg,
  input  logic [1:0]          src_sel,
  input  logic                sw_trig,
  input  logic                ext_trig,
  output logic                trig_pulse,
  output logic [CNT_W-1:0]    trig_index
);
  localparam int HYST = ((2**SAMPLE_W) * HYST_PCT + 50) / 100;

  logic signed [SAMPLE_W-1:0] lvl_c;
  logic                       ch_fire, ch_armed, fire_now;
  logic [CNT_W-1:0]           sample_cnt;

  trg_level_clamp #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W)) u_clamp (
    .lvl_raw (signed'(trig_level)),
    .lvl     (lvl_c)
  );

  trg_hyst_arm #(.SAMPLE_W(SAMPLE_W), .HYST(HYST)) u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .valid     (smp_valid),
    .smp       (signed'(smp_data)),
    .lvl       (lvl_c),
    .slope_neg (slope_neg),
    .fire      (ch_fire),
    .armed     (ch_armed)
  );

  trg_src_select u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .valid   (smp_valid),
    .src_sel (src_sel),
    .sw_stb  (sw_trig),
    .ext_stb (ext_trig),
    .ch_fire (ch_fire),
    .fire    (fire_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_cnt <= '0;
      trig_pulse <= 1'b0;
      trig_index <= '0;
    end else begin
      trig_pulse <= fire_now;
      if (fire_now)  trig_index <= sample_cnt;
      if (smp_valid) sample_cnt <= sample_cnt + 1'b1;
    end
  end

  // R9
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(smp_valid && enable));

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> sample_cnt == CNT_W'($past(sample_cnt) + 1));

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(sample_cnt));

  // R10
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_pulse |-> $stable(trig_index));

  // R2
  chan_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(src_sel) == 2'd0) |-> $past(ch_armed));
endmodule

// File: tb/sim_hyst_edge_trigger.sv
module sim_hyst_edge_trigger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, smp_valid, slope_neg, sw_trig, ext_trig;
  logic [11:0] smp_data;
  logic [13:0] trig_level;
  logic [1:0]  src_sel;
  logic        trig_pulse;
  logic [31:0] trig_index;

  int errors = 0;
  int checks = 0;
  int vcount = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hyst_edge_trigger u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
    .smp_data(smp_data), .trig_level(trig_level), .slope_neg(slope_neg),
    .src_sel(src_sel), .sw_trig(sw_trig), .ext_trig(ext_trig),
    .trig_pulse(trig_pulse), .trig_index(trig_index)
  );

  typedef struct packed {
    logic              en;
    logic [1:0]        src;
    logic              neg;
    logic signed [13:0] lvl;
    logic signed [11:0] x;
    logic [3:0]        req;
    logic              expt;
  } vec_t;

  // channel-source vectors, every one a valid sample
  localparam vec_t VEC [20] = '{
    '{1'b1, 2'd0, 1'b0,  14'sd0,     12'sd0,    4'd1,  1'b0}, // R1 not armed yet
    '{1'b1, 2'd0, 1'b0,  14'sd0,     12'sd100,  4'd2,  1'b0},
    '{1'b1, 2'd0, 1'b0,  14'sd0,    -12'sd204,  4'd4,  1'b0}, // R4 inside band
    '{1'b1, 2'd0, 1'b0,  14'sd0,     12'sd10,   4'd4,  1'b0},
    '{1'b1, 2'd0, 1'b0,  14'sd0,    -12'sd205,  4'd2,  1'b0}, // R2 arms
    '{1'b1, 2'd0, 1'b0,  14'sd0,    -12'sd1,    4'd2,  1'b0},
    '{1'b1, 2'd0, 1'b0,  14'sd0,     12'sd0,    4'd2,  1'b1}, // R2 fires at level
    '{1'b1, 2'd0, 1'b0,  14'sd0,     12'sd50,   4'd5,  1'b0}, // R5 disarmed
    '{1'b1, 2'd0, 1'b0,  14'sd0,    -12'sd300,  4'd2,  1'b0},
    '{1'b1, 2'd0, 1'b0,  14'sd0,     12'sd300,  4'd2,  1'b1},
    '{1'b1, 2'd0, 1'b1,  14'sd100,   12'sd304,  4'd3,  1'b0}, // R3 below band
    '{1'b1, 2'd0, 1'b1,  14'sd100,   12'sd50,   4'd3,  1'b0},
    '{1'b1, 2'd0, 1'b1,  14'sd100,   12'sd305,  4'd3,  1'b0}, // R3 arms
    '{1'b1, 2'd0, 1'b1,  14'sd100,   12'sd101,  4'd3,  1'b0},
    '{1'b1, 2'd0, 1'b1,  14'sd100,   12'sd100,  4'd3,  1'b1}, // R3 fires
    '{1'b1, 2'd0, 1'b1,  14'sd100,  -12'sd2048, 4'd5,  1'b0},
    '{1'b1, 2'd0, 1'b0,  14'sd3000,  12'sd1000, 4'd6,  1'b0}, // R6 level clamps to 2047
    '{1'b1, 2'd0, 1'b0,  14'sd3000,  12'sd2047, 4'd6,  1'b1},
    '{1'b1, 2'd0, 1'b1, -14'sd3000,  12'sd0,    4'd6,  1'b0}, // R6 level clamps to -2048
    '{1'b1, 2'd0, 1'b1, -14'sd3000, -12'sd2048, 4'd6,  1'b1}
  };

  task automatic check_bit(input logic act, input logic exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_idx(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d trig_index: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle and checks after the rising edge
  task automatic step(input logic en, input logic [1:0] src, input logic neg,
                      input logic [13:0] lvl, input logic [11:0] x, input logic vld,
                      input logic sw, input logic ext, input logic expt, input int req);
    int idx_exp;
    idx_exp    = vcount;
    enable     = en;
    src_sel    = src;
    slope_neg  = neg;
    trig_level = lvl;
    smp_data   = x;
    smp_valid  = vld;
    sw_trig    = sw;
    ext_trig   = ext;
    if (vld) vcount++;
    @(negedge clk);
    check_bit(trig_pulse, expt, req, "trig_pulse");
    if (expt && trig_pulse === 1'b1) check_idx(trig_index, 32'(idx_exp), 10); // R10
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; smp_valid = 1'b0; slope_neg = 1'b0;
    sw_trig = 1'b0; ext_trig = 1'b0; smp_data = '0; trig_level = '0; src_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_bit(trig_pulse, 1'b0, 1, "reset trig_pulse");
    check_idx(trig_index, 32'd0, 1);

    foreach (VEC[i])
      step(VEC[i].en, VEC[i].src, VEC[i].neg, VEC[i].lvl, VEC[i].x,
           1'b1, 1'b0, 1'b0, VEC[i].expt, int'(VEC[i].req));

    // R11: invalid cycle cannot arm
    step(1, 2'd0, 0, 14'sd0, -12'sd300, 0, 0, 0, 0, 11);
    step(1, 2'd0, 0, 14'sd0,  12'sd300, 1, 0, 0, 0, 11);
    // R9: disable clears arm
    step(1, 2'd0, 0, 14'sd0, -12'sd300, 1, 0, 0, 0, 9);
    step(0, 2'd0, 0, 14'sd0, -12'sd100, 1, 0, 0, 0, 9);
    step(1, 2'd0, 0, 14'sd0,  12'sd300, 1, 0, 0, 0, 9);
    // R8: external strobe with channel selected is ignored
    step(1, 2'd0, 0, 14'sd0,  12'sd0,   1, 0, 1, 0, 8);
    step(1, 2'd1, 0, 14'sd0,  12'sd0,   1, 0, 0, 0, 8);
    // R8: strobes with no source selected are ignored
    step(1, 2'd3, 0, 14'sd0,  12'sd0,   1, 1, 1, 0, 8);
    step(1, 2'd2, 0, 14'sd0,  12'sd0,   1, 0, 0, 0, 8);
    // R7: software strobe in the same cycle as a sample
    step(1, 2'd2, 0, 14'sd0,  12'sd0,   1, 1, 0, 1, 7);
    step(1, 2'd2, 0, 14'sd0,  12'sd0,   1, 0, 0, 0, 7);
    // R7: software strobe between samples waits for the next one, fires once
    step(1, 2'd2, 0, 14'sd0, -12'sd900, 0, 1, 0, 0, 7);
    step(1, 2'd2, 0, 14'sd0, -12'sd900, 0, 0, 0, 0, 7);
    step(1, 2'd2, 0, 14'sd0, -12'sd900, 1, 0, 0, 1, 7);
    step(1, 2'd2, 0, 14'sd0, -12'sd900, 1, 0, 0, 0, 7);
    // R8: external strobe pending then fired
    step(1, 2'd1, 1, 14'sd0,  12'sd5,   0, 0, 1, 0, 8);
    step(1, 2'd1, 1, 14'sd0, -12'sd2048, 1, 0, 0, 1, 8);
    // R9: strobe while disabled dropped
    step(0, 2'd2, 0, 14'sd0,  12'sd0,   1, 1, 0, 0, 9);
    step(1, 2'd2, 0, 14'sd0,  12'sd0,   1, 0, 0, 0, 9);
    // R9: pending strobe cleared by disable
    step(1, 2'd2, 0, 14'sd0,  12'sd0,   0, 1, 0, 0, 9);
    step(0, 2'd2, 0, 14'sd0,  12'sd0,   0, 0, 0, 0, 9);
    step(1, 2'd2, 0, 14'sd0,  12'sd0,   1, 0, 0, 0, 9);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule